// File: doc/BRIEF.md
# Store Commit Queue

This block is a circular buffer that keeps store operations from the cycle they leave execution until their data sits in the data cache. Every occupied slot is in one of three regions: finished, completed or committed. The remaining slots are free. Each region boundary is a separate pointer, so a store moves forward by pointer movement alone and its address and data are never copied.

The in-order retire logic moves the oldest finished store into the completed region. A commit request moves the oldest completed store into the committed region. Committed stores are sent to the cache one at a time, oldest first. A hit marks the store written. A miss marks it as waiting on a line reload, and the next committed store may then try the cache while that reload is in flight. The oldest slot is freed only once it is written. After a reload, the head pointer passes every contiguous written slot in a single cycle.

Top module: `store_commit_queue`

## Requirements
- R1: After reset, all three region counts are zero, `fin_ready` is 1, `cw_valid` is 0 and `err` is 0.
- R2: A finish with `fin_ready` high adds one store to the finished region on the next cycle. `fin_ready` is low exactly when all DEPTH (8) slots are occupied, and a finish offered then is dropped.
- R3: `cpl_req` moves the oldest finished store into the completed region. `n_finished` falls by one and `n_completed` rises by one.
- R4: `cmt_req` moves the oldest completed store into the committed region. `n_completed` falls by one and `n_committed` rises by one.
- R5: `cw_valid` presents the oldest committed store that has not yet tried the cache. `cw_idx` is its slot number, counted from 0 in allocation order modulo DEPTH, and `cw_addr` and `cw_data` are the values it was finished with. The store counts as issued on any cycle where `cw_valid` is high, and `cw_hit` in that same cycle gives the result.
- R6: A store that hits is freed once every older committed store has been written. It leaves `n_committed` on the second clock edge after the hit.
- R7: A store that misses keeps the head slot occupied until `rl_done` arrives with `rl_idx` equal to its slot. Younger committed stores keep trying the cache in the meantime.
- R8: No more than MAX_RELOADS (2) misses are outstanding at once. While that many are outstanding, `cw_valid` stays low. It rises again in the cycle after a matching `rl_done`.
- R9: On one clock edge, the head advances over every contiguous oldest store that has been written, whether by a hit or by a finished reload.
- R10: A `cpl_req` while the finished region is empty, or a `cmt_req` while the completed region is empty, changes no count and sets `err`. `err` then stays set until reset.
- R11: An `rl_done` whose `rl_idx` names a slot with no outstanding miss has no effect. Counts, `cw_valid` and the reload budget are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fin_valid | input | 1 | A store leaves execution this cycle |
| fin_addr | input | AW | Address of the finishing store |
| fin_data | input | DW | Data of the finishing store |
| fin_ready | output | 1 | At least one slot is free |
| cpl_req | input | 1 | Complete the oldest finished store |
| cmt_req | input | 1 | Commit the oldest completed store |
| cw_valid | output | 1 | Cache write presented |
| cw_idx | output | log2(DEPTH) | Slot number of the presented store |
| cw_addr | output | AW | Address of the presented store |
| cw_data | output | DW | Data of the presented store |
| cw_hit | input | 1 | Cache result for the presented store, same cycle |
| rl_done | input | 1 | A line reload has finished |
| rl_idx | input | log2(DEPTH) | Slot whose reload finished |
| n_finished | output | log2(DEPTH)+1 | Stores in the finished region |
| n_completed | output | log2(DEPTH)+1 | Stores in the completed region |
| n_committed | output | log2(DEPTH)+1 | Stores in the committed region |
| err | output | 1 | Sticky flag for a completion or commit request on an empty region |

## Verification
Several things can land on the same clock edge: a reload for the head store, a hit on a younger store, and a commit request that pushes the next store into the committed region. The head then has to step over a run of written slots while the issue point and the commit boundary also move. A directed sequence commits five stores back to back and answers the cache with miss, hit, hit, miss in those same cycles. It then releases the head's reload. The bench judges the outcome by the exact drop in `n_committed` and by `cw_valid` reopening. A long random phase then overlaps finish, completion, commit, cache results and reloads freely, and a cycle-accurate model in the bench compares every output on every cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef struct packed {
        logic pend;
        logic done;
    } sq_flags_t;

    typedef enum logic [1:0] {
        ISS_NONE = 2'd0,
        ISS_HIT  = 2'd1,
        ISS_MISS = 2'd2
    } sq_issue_e;

    function automatic sq_issue_e sq_classify(input logic v, input logic hit);
        if (!v)
            return ISS_NONE;
        return hit ? ISS_HIT : ISS_MISS;
    endfunction

endpackage

// File: rtl/sq_entry_file.sv
module sq_entry_file
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  sq_issue_e        iss,
    input  logic [IW-1:0]    iss_idx,
    input  logic             rl_en,
    input  logic [IW-1:0]    rl_idx,
    output logic             rl_take,
    output logic [DEPTH-1:0] done_vec,
    output logic [DEPTH-1:0] pend_vec
);
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    sq_flags_t     flg_q  [DEPTH];

    assign rd_addr = addr_q[rd_idx];
    assign rd_data = data_q[rd_idx];
    assign rl_take = rl_en && flg_q[rl_idx].pend;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            done_vec[i] = flg_q[i].done;
            pend_vec[i] = flg_q[i].pend;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr_q[wr_idx] <= wr_addr;
            data_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                flg_q[i] <= '0;
        end else begin
            if (wr_en)
                flg_q[wr_idx] <= '0;
            if (rl_take) begin
                flg_q[rl_idx].pend <= 1'b0;
                flg_q[rl_idx].done <= 1'b1;
            end
            if (iss == ISS_HIT)
                flg_q[iss_idx].done <= 1'b1;
            else if (iss == ISS_MISS)
                flg_q[iss_idx].pend <= 1'b1;
        end
    end

    // a new allocation never lands on a slot that still waits on a reload
    assert_alloc_free_R7: assert property (@(posedge clk) disable iff (rst)
        rl_take |-> !(wr_en && wr_idx == rl_idx));

    // the store sent to the cache is never one already waiting on a reload
    assert_issue_fresh_R5: assert property (@(posedge clk) disable iff (rst)
        (iss != ISS_NONE) |-> !flg_q[iss_idx].pend);

endmodule

// File: rtl/sq_retire_scan.sv
module sq_retire_scan #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int PW    = 4
) (
    input  logic [DEPTH-1:0] done_vec,
    input  logic [IW-1:0]    head,
    input  logic [PW-1:0]    limit,
    output logic [PW-1:0]    n_free
);
    logic          run;
    logic [IW-1:0] idx;

    always_comb begin
        n_free = '0;
        run    = 1'b1;
        idx    = head;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head + IW'(i);
            if (run && PW'(i) < limit && done_vec[idx])
                n_free = n_free + PW'(1);
            else
                run = 1'b0;
        end
    end

endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue
    import sq_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int MAX_RELOADS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fin_valid,
    input  logic [AW-1:0]            fin_addr,
    input  logic [DW-1:0]            fin_data,
    output logic                     fin_ready,
    input  logic                     cpl_req,
    input  logic                     cmt_req,
    output logic                     cw_valid,
    output logic [$clog2(DEPTH)-1:0] cw_idx,
    output logic [AW-1:0]            cw_addr,
    output logic [DW-1:0]            cw_data,
    input  logic                     cw_hit,
    input  logic                     rl_done,
    input  logic [$clog2(DEPTH)-1:0] rl_idx,
    output logic [$clog2(DEPTH):0]   n_finished,
    output logic [$clog2(DEPTH):0]   n_completed,
    output logic [$clog2(DEPTH):0]   n_committed,
    output logic                     err
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;
    localparam int RW = $clog2(MAX_RELOADS + 1);

    // oldest .. youngest: [cmt, iss) tried, [iss, cmp) waiting, [cmp, fin) completed, [fin, tail) finished
    logic [PW-1:0] p_tail, p_fin, p_cmp, p_iss, p_cmt;
    logic [RW-1:0] pend_cnt;
    logic          err_q;

    logic [PW-1:0]    occ, issuable, issued, ret_n;
    logic [DEPTH-1:0] done_vec, pend_vec;
    logic             rl_take, alloc;
    sq_issue_e        iss;

    assign occ         = p_tail - p_cmt;
    assign n_finished  = p_tail - p_fin;
    assign n_completed = p_fin - p_cmp;
    assign n_committed = p_cmp - p_cmt;
    assign issuable    = p_cmp - p_iss;
    assign issued      = p_iss - p_cmt;

    assign fin_ready = (occ != PW'(DEPTH));
    assign alloc     = fin_valid && fin_ready;
    assign cw_valid  = (issuable != '0) && (pend_cnt < RW'(MAX_RELOADS));
    assign cw_idx    = p_iss[IW-1:0];
    assign iss       = sq_classify(cw_valid, cw_hit);
    assign err       = err_q;

    sq_entry_file #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW)) u_entries (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (alloc),
        .wr_idx   (p_tail[IW-1:0]),
        .wr_addr  (fin_addr),
        .wr_data  (fin_data),
        .rd_idx   (p_iss[IW-1:0]),
        .rd_addr  (cw_addr),
        .rd_data  (cw_data),
        .iss      (iss),
        .iss_idx  (p_iss[IW-1:0]),
        .rl_en    (rl_done),
        .rl_idx   (rl_idx),
        .rl_take  (rl_take),
        .done_vec (done_vec),
        .pend_vec (pend_vec)
    );

    sq_retire_scan #(.DEPTH(DEPTH), .IW(IW), .PW(PW)) u_scan (
        .done_vec (done_vec),
        .head     (p_cmt[IW-1:0]),
        .limit    (issued),
        .n_free   (ret_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p_tail   <= '0;
            p_fin    <= '0;
            p_cmp    <= '0;
            p_iss    <= '0;
            p_cmt    <= '0;
            pend_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            if (alloc)
                p_tail <= p_tail + PW'(1);
            if (cpl_req) begin
                if (n_finished != '0) p_fin <= p_fin + PW'(1);
                else                  err_q <= 1'b1;
            end
            if (cmt_req) begin
                if (n_completed != '0) p_cmp <= p_cmp + PW'(1);
                else                   err_q <= 1'b1;
            end
            if (cw_valid)
                p_iss <= p_iss + PW'(1);
            p_cmt    <= p_cmt + ret_n;
            pend_cnt <= pend_cnt + RW'(iss == ISS_MISS) - RW'(rl_take);
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        occ <= PW'(DEPTH));

    assert_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !fin_ready |=> (p_tail == $past(p_tail)));

    assert_region_order_R4: assert property (@(posedge clk) disable iff (rst)
        (issued <= n_committed) && (n_committed <= occ));

    assert_reload_cap_R8: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= RW'(MAX_RELOADS));

    assert_pend_track_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(pend_vec) == int'(pend_cnt));

    assert_retire_bound_R9: assert property (@(posedge clk) disable iff (rst)
        ret_n <= issued);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: tb/sim_store_commit_queue.sv
`timescale 1ns/1ps
module sim_store_commit_queue;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int MAXRL = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          fin_valid, cpl_req, cmt_req, cw_hit, rl_done;
    logic [AW-1:0] fin_addr;
    logic [DW-1:0] fin_data;
    logic [2:0]    rl_idx;
    logic          fin_ready, cw_valid, err;
    logic [2:0]    cw_idx;
    logic [AW-1:0] cw_addr;
    logic [DW-1:0] cw_data;
    logic [3:0]    n_finished, n_completed, n_committed;

    int n_chk = 0;
    int n_bad = 0;

    // bench reference state
    logic [AW-1:0] m_addr [DEPTH];
    logic [DW-1:0] m_data [DEPTH];
    bit            m_pend [DEPTH];
    bit            m_done [DEPTH];
    int m_tail, m_fin, m_cmp, m_iss, m_cmt, m_rl;
    bit m_err;

    always #10 clk = ~clk;

    store_commit_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MAX_RELOADS(MAXRL)) u0 (
        .clk(clk), .rst(rst),
        .fin_valid(fin_valid), .fin_addr(fin_addr), .fin_data(fin_data), .fin_ready(fin_ready),
        .cpl_req(cpl_req), .cmt_req(cmt_req),
        .cw_valid(cw_valid), .cw_idx(cw_idx), .cw_addr(cw_addr), .cw_data(cw_data), .cw_hit(cw_hit),
        .rl_done(rl_done), .rl_idx(rl_idx),
        .n_finished(n_finished), .n_completed(n_completed), .n_committed(n_committed),
        .err(err)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_ready();
        return (m_tail - m_cmt) < DEPTH;
    endfunction

    function automatic bit exp_cwv();
        return (m_iss < m_cmp) && (m_rl < MAXRL);
    endfunction

    task automatic compare_all();
        chk("R2", "fin_ready", fin_ready, exp_ready());
        chk("R2", "n_finished", n_finished, m_tail - m_fin);
        chk("R3", "n_completed", n_completed, m_fin - m_cmp);
        chk("R4", "n_committed", n_committed, m_cmp - m_cmt);
        chk("R5", "cw_valid", cw_valid, exp_cwv());
        if (exp_cwv()) begin
            chk("R5", "cw_idx", cw_idx, m_iss % DEPTH);
            chk("R5", "cw_addr", cw_addr, m_addr[m_iss % DEPTH]);
            chk("R5", "cw_data", cw_data, m_data[m_iss % DEPTH]);
        end
        chk("R10", "err", err, m_err);
    endtask

    // next state of the reference from the current state and the inputs of this cycle
    task automatic model_step(input bit fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                              input bit cpl, input bit cmt, input bit hit, input bit rl, input int rli);
        bit rdy = exp_ready();
        bit cwv = exp_cwv();
        int o_tail = m_tail;
        int o_fin  = m_fin;
        int n = 0;
        while (m_cmt + n < m_iss && m_done[(m_cmt + n) % DEPTH]) n++;
        if (rl && m_pend[rli]) begin
            m_pend[rli] = 0;
            m_done[rli] = 1;
            m_rl--;
        end
        if (cwv) begin
            if (hit) m_done[m_iss % DEPTH] = 1;
            else begin m_pend[m_iss % DEPTH] = 1; m_rl++; end
            m_iss++;
        end
        m_cmt += n;
        if (fv && rdy) begin
            m_addr[m_tail % DEPTH] = fa;
            m_data[m_tail % DEPTH] = fd;
            m_pend[m_tail % DEPTH] = 0;
            m_done[m_tail % DEPTH] = 0;
            m_tail++;
        end
        if (cpl) begin
            if (o_tail > m_fin) m_fin++; else m_err = 1;
        end
        if (cmt) begin
            if (o_fin > m_cmp) m_cmp++; else m_err = 1;
        end
    endtask

    task automatic step(input bit fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                        input bit cpl, input bit cmt, input bit hit, input bit rl, input int rli);
        fin_valid = fv; fin_addr = fa; fin_data = fd;
        cpl_req = cpl; cmt_req = cmt; cw_hit = hit;
        rl_done = rl; rl_idx = 3'(rli);
        model_step(fv, fa, fd, cpl, cmt, hit, rl, rli);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input bit hit);
        step(0, '0, '0, 0, 0, hit, 0, 0);
    endtask

    initial begin
        #(20ns * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd6401));
        m_tail = 0; m_fin = 0; m_cmp = 0; m_iss = 0; m_cmt = 0; m_rl = 0; m_err = 0;
        for (int i = 0; i < DEPTH; i++) begin
            m_pend[i] = 0; m_done[i] = 0; m_addr[i] = '0; m_data[i] = '0;
        end
        rst = 1'b1;
        fin_valid = 0; fin_addr = '0; fin_data = '0; cpl_req = 0; cmt_req = 0;
        cw_hit = 0; rl_done = 0; rl_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "n_finished", n_finished, 0);
        chk("R1", "n_completed", n_completed, 0);
        chk("R1", "n_committed", n_committed, 0);
        chk("R1", "fin_ready", fin_ready, 1);
        chk("R1", "cw_valid", cw_valid, 0);
        chk("R1", "err", err, 0);

        // R10: completion on an empty finished region
        step(0, '0, '0, 1, 0, 0, 0, 0);
        chk("R10", "err after empty completion", err, 1);
        chk("R10", "n_completed unchanged", n_completed, 0);
        step(0, '0, '0, 0, 1, 0, 0, 0);
        chk("R10", "n_committed unchanged", n_committed, 0);
        chk("R10", "err sticky", err, 1);

        // five stores, complete them
        for (int i = 0; i < 5; i++)
            step(1, 32'h1000 + 32'(i * 4), 32'hA0 + 32'(i), 0, 0, 0, 0, 0);
        chk("R2", "five finished", n_finished, 5);
        for (int i = 0; i < 5; i++)
            step(0, '0, '0, 1, 0, 0, 0, 0);
        chk("R3", "five completed", n_completed, 5);
        chk("R3", "none finished", n_finished, 0);

        // commit while the cache answers miss, hit, hit, miss
        step(0, '0, '0, 0, 1, 0, 0, 0);
        chk("R5", "first presented slot", cw_idx, 0);
        chk("R5", "first presented addr", cw_addr, 32'h1000);
        step(0, '0, '0, 0, 1, 0, 0, 0);
        chk("R7", "younger presented behind miss", cw_idx, 1);
        step(0, '0, '0, 0, 1, 1, 0, 0);
        step(0, '0, '0, 0, 1, 1, 0, 0);
        chk("R6", "hits wait behind missing head", n_committed, 4);
        step(0, '0, '0, 0, 1, 0, 0, 0);
        chk("R8", "two reloads stall cache port", cw_valid, 0);
        chk("R7", "head still held", n_committed, 5);

        // R11: reload for a slot with no outstanding miss
        step(0, '0, '0, 0, 0, 0, 1, 4);
        chk("R11", "cw_valid still low", cw_valid, 0);
        chk("R11", "n_committed unchanged", n_committed, 5);

        // reload of the head
        step(0, '0, '0, 0, 0, 0, 1, 0);
        chk("R8", "port reopens after reload", cw_valid, 1);
        chk("R8", "next slot presented", cw_idx, 4);
        step(0, '0, '0, 0, 0, 1, 0, 0);
        chk("R9", "three freed in one cycle", n_committed, 2);
        step(0, '0, '0, 0, 0, 0, 1, 3);
        chk("R7", "second miss written, not yet freed", n_committed, 2);
        idle(0);
        chk("R9", "remaining two freed", n_committed, 0);
        chk("R6", "queue drained", fin_ready, 1);

        // R2: fill up and offer one more
        for (int i = 0; i < DEPTH; i++)
            step(1, 32'h2000 + 32'(i), 32'hB0 + 32'(i), 0, 0, 0, 0, 0);
        chk("R2", "full drops ready", fin_ready, 0);
        step(1, 32'hDEAD, 32'hBEEF, 0, 0, 0, 0, 0);
        chk("R2", "finish ignored when full", n_finished, DEPTH);

        // random overlap of every input
        for (int c = 0; c < 4000; c++) begin
            bit fv  = ($urandom % 2) == 0;
            bit cpl = ($urandom % 3) == 0;
            bit cmt = ($urandom % 3) == 0;
            bit hit = ($urandom % 2) == 0;
            bit rl  = 0;
            int rli = int'($urandom % DEPTH);
            if (($urandom % 3) == 0) begin
                int off = int'($urandom % DEPTH);
                for (int k = 0; k < DEPTH; k++) begin
                    if (!rl && m_pend[(off + k) % DEPTH]) begin
                        rl = 1;
                        rli = (off + k) % DEPTH;
                    end
                end
            end else if (($urandom % 16) == 0) begin
                rl = 1;
            end
            step(fv, $urandom, $urandom, cpl, cmt, hit, rl, rli);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule